// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits beside an SDRAM command bus and watches its control pins on every rising clock edge. It turns the chip-select, row strobe, column strobe, write enable, clock enable, bank address and A10 pins into one command code. It follows every bank through its life cycle, and it raises a one-cycle flag with a reason code whenever a command breaks the rules for the addressed bank or for the device as a whole. It only observes the bus and never drives it. A controller under test, or a bus-functional model in a larger environment, can use the flag as a protocol checker.

Each bank has a state machine with eight states. IDLE, OPENING (row activation in progress), OPEN, RD_BURST, WR_BURST, RD_BURST_AP, WR_BURST_AP (bursts with auto-precharge) and CLOSING (precharge in progress). The transitions are as follows. ACT takes IDLE to OPENING, and a timer then takes OPENING to OPEN. READ or WRITE takes OPEN or a plain burst into a burst state, and the burst timer then takes it back to OPEN. An auto-precharge burst goes to CLOSING when it ends. Burst terminate takes a plain burst to OPEN. PRE takes OPEN or a plain burst to CLOSING, and a timer then takes CLOSING to IDLE. A device-level machine has three states: READY, REFRESHING (entered by auto-refresh) and MODE_SETTING (entered by mode-register set). Each of the last two returns to READY when its timer ends. Every wait is a cycle count derived from a nanosecond parameter and the clock period.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cke high and cs_n low, {ras_n,cas_n,we_n} decodes as 111 NOP(0), 011 ACT(1), 101 READ(2), or READA(3) when a10=1, 100 WRITE(4), or WRITEA(5) when a10=1, 010 PRE(6), or PREA(7) when a10=1, 110 TBST(8), 001 REF(9) and 000 MRS(10). When cs_n is high or cke is low, the code is NOP(0). A NOP is never flagged.
- R2: cmd_code_o, illegal_o and reason_o are registered and show the command taken at the previous rising edge. After reset the code is 0, there is no flag, every bank is IDLE(0) and the device is READY(0). The bank state encoding is IDLE 0, OPENING 1, OPEN 2, RD_BURST 3, WR_BURST 4, RD_BURST_AP 5, WR_BURST_AP 6, CLOSING 7. bank_state_o[3b+2:3b] holds bank b.
- R3: An ACT accepted at edge E opens the bank. A READ or WRITE to that bank is legal from edge E+tRCD. Before that edge it is flagged with reason 3 (timing).
- R4: READ, READA, WRITE, WRITEA or TBST to an IDLE bank is flagged with reason 1 (bank state). ACT to an OPEN or bursting bank is also flagged with reason 1.
- R5: PRE to an open bank earlier than tRAS cycles after its ACT is flagged with reason 3. A legal PRE at edge E makes ACT legal from E+tRP. PRE to an IDLE or CLOSING bank is legal and changes nothing.
- R6: REF or MRS while any bank is not IDLE is flagged with reason 2 (all-idle).
- R7: REF at edge E puts the device in REFRESHING(1) until E+tRC. MRS puts it in MODE_SETTING(2) until E+tRSC. Any command other than NOP during these waits is flagged with reason 3.
- R8: A plain burst issued at E lasts BURST_LEN cycles and then the bank is OPEN. A READ or WRITE to the same bank during the burst restarts it. TBST returns the bank to OPEN at once. PRE sends it to CLOSING.
- R9: During an auto-precharge burst, READ, WRITE, PRE or TBST to that bank is flagged with reason 1. For a burst issued at E, precharge starts at E+BURST_LEN and ACT is legal from E+BURST_LEN+tRP.
- R10: A flagged command changes no bank state and no device state.
- R11: PREA applies the PRE rule to every bank at once. If any bank breaks a timing rule, the reason is 3. Otherwise, if any bank breaks a state rule, the reason is 1. When PREA is legal, every open or bursting bank goes to CLOSING.
- R12: Each wait equals ceil(ns / CLK_NS). The defaults give tRCD=2, tRP=2, tRAS=5, tRC=7 and tRSC=2.
- R13: A command addressed to one bank leaves the other banks unchanged, apart from PREA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| cke | input | 1 | Clock enable; low means no command this cycle |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all option |
| cmd_code_o | output | 4 | Decoded command code (R1) |
| bank_state_o | output | 3*NUM_BANKS | Per-bank state (R2 encoding) |
| dev_state_o | output | 2 | Device state: 0 READY, 1 REFRESHING, 2 MODE_SETTING |
| illegal_o | output | 1 | One-cycle flag for a rule violation |
| reason_o | output | 2 | 0 none, 1 bank state, 2 not all idle, 3 timing |

## Verification
The case that needs care is a bank's timer running out on the same edge that a new command reaches that bank. On that edge the timer transition and the legality decision fall in one cycle. The bench sweeps the distance between an ACT, PRE, REF, MRS or auto-precharge burst and the next command through every value around each limit. At the limit itself it expects the command to be legal, and one cycle earlier it expects the flag with the timing or bank-state reason. PREA is also issued while the banks sit in different states, so that state-rule and timing-rule results from several banks have to be merged in one cycle and judged against the priority order.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [3:0] {
        CMD_NOP    = 4'd0,
        CMD_ACT    = 4'd1,
        CMD_READ   = 4'd2,
        CMD_READA  = 4'd3,
        CMD_WRITE  = 4'd4,
        CMD_WRITEA = 4'd5,
        CMD_PRE    = 4'd6,
        CMD_PREA   = 4'd7,
        CMD_TBST   = 4'd8,
        CMD_REF    = 4'd9,
        CMD_MRS    = 4'd10
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_OPENING = 3'd1,
        BK_OPEN    = 3'd2,
        BK_RD      = 3'd3,
        BK_WR      = 3'd4,
        BK_RD_AP   = 3'd5,
        BK_WR_AP   = 3'd6,
        BK_CLOSING = 3'd7
    } bank_e;

    typedef enum logic [1:0] {
        DV_READY   = 2'd0,
        DV_REFRESH = 2'd1,
        DV_MODESET = 2'd2
    } dev_e;

    typedef enum logic [1:0] {
        RSN_NONE    = 2'd0,
        RSN_BANK    = 2'd1,
        RSN_ALLIDLE = 2'd2,
        RSN_TIMING  = 2'd3
    } rsn_e;

    // Round a nanosecond wait up to whole clock cycles, never below one.
    function automatic int ns2cyc(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdm_cmd_decode.sv
module sdm_cmd_decode
    import sdm_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic a10,
    output cmd_e cmd_o
);

    always_comb begin
        cmd_o = CMD_NOP;
        if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd_o = CMD_NOP;
                3'b011:  cmd_o = CMD_ACT;
                3'b010:  cmd_o = a10 ? CMD_PREA : CMD_PRE;
                3'b101:  cmd_o = a10 ? CMD_READA : CMD_READ;
                3'b100:  cmd_o = a10 ? CMD_WRITEA : CMD_WRITE;
                3'b110:  cmd_o = CMD_TBST;
                3'b001:  cmd_o = CMD_REF;
                default: cmd_o = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdm_bank_fsm.sv
module sdm_bank_fsm
    import sdm_pkg::*;
#(
    parameter int TRCD_C = 2,
    parameter int TRP_C  = 2,
    parameter int TRAS_C = 5,
    parameter int BL     = 4,
    parameter int CW     = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  cmd_e  cmd_i,
    input  logic  hit_i,
    input  logic  accept_i,
    output bank_e st_o,
    output logic  ras_ok_o
);

    localparam logic [CW-1:0] LD_RCD = CW'(TRCD_C - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(TRP_C - 1);
    localparam logic [CW-1:0] LD_RPF = CW'(TRP_C);
    localparam logic [CW-1:0] LD_RAS = CW'(TRAS_C - 1);
    localparam logic [CW-1:0] LD_BL  = CW'(BL - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);

    bank_e         st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [CW-1:0] ras, ras_n;
    logic          is_ap;
    logic          is_rd;

    assign st_o     = st;
    assign ras_ok_o = (ras == '0);
    assign is_ap    = (cmd_i == CMD_READA) || (cmd_i == CMD_WRITEA);
    assign is_rd    = (cmd_i == CMD_READ)  || (cmd_i == CMD_READA);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= BK_IDLE;
            cnt <= '0;
            ras <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            ras <= ras_n;
        end
    end

    // Next state: timers first, then an accepted command overrides
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        ras_n = (ras != '0) ? ras - ONE : ras;

        unique case (st)
            BK_OPENING: if (cnt <= ONE) st_n = BK_OPEN;    else cnt_n = cnt - ONE;
            BK_CLOSING: if (cnt <= ONE) st_n = BK_IDLE;    else cnt_n = cnt - ONE;
            BK_RD, BK_WR: if (cnt <= ONE) st_n = BK_OPEN;  else cnt_n = cnt - ONE;
            BK_RD_AP, BK_WR_AP: begin
                if (cnt <= ONE) begin
                    st_n  = BK_CLOSING;
                    cnt_n = LD_RPF;
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            default: ;
        endcase

        if (accept_i && hit_i) begin
            unique case (cmd_i)
                CMD_ACT: begin
                    if (st == BK_IDLE) begin
                        st_n  = (TRCD_C > 1) ? BK_OPENING : BK_OPEN;
                        cnt_n = LD_RCD;
                        ras_n = LD_RAS;
                    end
                end
                CMD_READ, CMD_READA, CMD_WRITE, CMD_WRITEA: begin
                    if (st inside {BK_OPEN, BK_RD, BK_WR}) begin
                        if (BL > 1) begin
                            st_n  = is_ap ? (is_rd ? BK_RD_AP : BK_WR_AP)
                                          : (is_rd ? BK_RD : BK_WR);
                            cnt_n = LD_BL;
                        end else if (is_ap) begin
                            st_n  = BK_CLOSING;
                            cnt_n = LD_RPF;
                        end else begin
                            st_n  = BK_OPEN;
                        end
                    end
                end
                CMD_PRE, CMD_PREA: begin
                    if (st inside {BK_OPEN, BK_RD, BK_WR}) begin
                        st_n  = (TRP_C > 1) ? BK_CLOSING : BK_IDLE;
                        cnt_n = LD_RP;
                    end
                end
                CMD_TBST: begin
                    if (st inside {BK_RD, BK_WR}) st_n = BK_OPEN;
                end
                default: ;
            endcase
        end
    end

    // R3
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == BK_IDLE |=> st inside {BK_IDLE, BK_OPENING, BK_OPEN});

    // R8
    rd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == BK_RD) |-> $past(st) inside {BK_OPEN, BK_WR});

    // R5
    close_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == BK_CLOSING |=> st inside {BK_CLOSING, BK_IDLE});

endmodule

// File: rtl/sdm_dev_fsm.sv
module sdm_dev_fsm
    import sdm_pkg::*;
#(
    parameter int TRC_C  = 7,
    parameter int TRSC_C = 2,
    parameter int CW     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd_i,
    input  logic accept_i,
    output dev_e st_o
);

    localparam logic [CW-1:0] LD_RC  = CW'(TRC_C - 1);
    localparam logic [CW-1:0] LD_RSC = CW'(TRSC_C - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);

    dev_e          st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    assign st_o = st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DV_READY;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            DV_READY: begin
                if (accept_i && cmd_i == CMD_REF && TRC_C > 1) begin
                    st_n  = DV_REFRESH;
                    cnt_n = LD_RC;
                end else if (accept_i && cmd_i == CMD_MRS && TRSC_C > 1) begin
                    st_n  = DV_MODESET;
                    cnt_n = LD_RSC;
                end
            end
            DV_REFRESH, DV_MODESET: begin
                if (cnt <= ONE) st_n = DV_READY;
                else            cnt_n = cnt - ONE;
            end
            default: st_n = DV_READY;
        endcase
    end

    // R7
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == DV_REFRESH |=> st inside {DV_REFRESH, DV_READY});

endmodule

// File: rtl/sdm_rule_check.sv
module sdm_rule_check
    import sdm_pkg::*;
#(
    parameter int NB  = 4,
    parameter int BAW = 2
) (
    input  cmd_e           cmd_i,
    input  logic [BAW-1:0] ba_i,
    input  bank_e          bst_i [NB],
    input  logic [NB-1:0]  ras_ok_i,
    input  dev_e           dev_i,
    output logic           illegal_o,
    output rsn_e           reason_o
);

    function automatic rsn_e bank_rule(input cmd_e c, input bank_e s, input logic rok);
        rsn_e r;
        r = RSN_NONE;
        case (c)
            CMD_ACT: begin
                if (s inside {BK_OPENING, BK_CLOSING}) r = RSN_TIMING;
                else if (s != BK_IDLE)                 r = RSN_BANK;
            end
            CMD_READ, CMD_READA, CMD_WRITE, CMD_WRITEA, CMD_TBST: begin
                if (s inside {BK_OPENING, BK_CLOSING})          r = RSN_TIMING;
                else if (!(s inside {BK_OPEN, BK_RD, BK_WR}))   r = RSN_BANK;
            end
            CMD_PRE, CMD_PREA: begin
                if (s == BK_OPENING)                            r = RSN_TIMING;
                else if (s inside {BK_RD_AP, BK_WR_AP})         r = RSN_BANK;
                else if (s inside {BK_OPEN, BK_RD, BK_WR} && !rok) r = RSN_TIMING;
            end
            default: r = RSN_NONE;
        endcase
        return r;
    endfunction

    logic any_busy_bank;
    logic prea_t, prea_b;
    rsn_e r_b;

    always_comb begin
        any_busy_bank = 1'b0;
        prea_t        = 1'b0;
        prea_b        = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (bst_i[b] != BK_IDLE) any_busy_bank = 1'b1;
            r_b = bank_rule(CMD_PREA, bst_i[b], ras_ok_i[b]);
            if (r_b == RSN_TIMING) prea_t = 1'b1;
            if (r_b == RSN_BANK)   prea_b = 1'b1;
        end
    end

    always_comb begin
        reason_o = RSN_NONE;
        if (cmd_i == CMD_NOP) begin
            reason_o = RSN_NONE;
        end else if (dev_i != DV_READY) begin
            reason_o = RSN_TIMING;
        end else if (cmd_i == CMD_REF || cmd_i == CMD_MRS) begin
            reason_o = any_busy_bank ? RSN_ALLIDLE : RSN_NONE;
        end else if (cmd_i == CMD_PREA) begin
            reason_o = prea_t ? RSN_TIMING : (prea_b ? RSN_BANK : RSN_NONE);
        end else begin
            reason_o = bank_rule(cmd_i, bst_i[ba_i], ras_ok_i[ba_i]);
        end
        illegal_o = (reason_o != RSN_NONE);
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CLK_NS    = 10,
    parameter int TRCD_NS   = 20,
    parameter int TRP_NS    = 20,
    parameter int TRAS_NS   = 50,
    parameter int TRC_NS    = 70,
    parameter int TRSC_NS   = 20,
    parameter int BURST_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic                         cke,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic                         a10,
    output logic [3:0]                   cmd_code_o,
    output logic [3*NUM_BANKS-1:0]       bank_state_o,
    output logic [1:0]                   dev_state_o,
    output logic                         illegal_o,
    output logic [1:0]                   reason_o
);

    localparam int BAW    = $clog2(NUM_BANKS);
    localparam int TRCD_C = ns2cyc(TRCD_NS, CLK_NS);
    localparam int TRP_C  = ns2cyc(TRP_NS, CLK_NS);
    localparam int TRAS_C = ns2cyc(TRAS_NS, CLK_NS);
    localparam int TRC_C  = ns2cyc(TRC_NS, CLK_NS);
    localparam int TRSC_C = ns2cyc(TRSC_NS, CLK_NS);
    localparam int MAXC   = imax(imax(imax(TRCD_C, TRP_C), imax(TRAS_C, TRC_C)),
                                 imax(TRSC_C, BURST_LEN));
    localparam int CW     = $clog2(MAXC + 2);

    cmd_e                 cmd;
    bank_e                bst [NUM_BANKS];
    logic [NUM_BANKS-1:0] ras_ok;
    dev_e                 dev_st;
    logic                 illegal_c;
    rsn_e                 reason_c;
    logic                 all_idle;

    sdm_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .a10   (a10),
        .cmd_o (cmd)
    );

    sdm_rule_check #(.NB(NUM_BANKS), .BAW(BAW)) u_rules (
        .cmd_i     (cmd),
        .ba_i      (ba),
        .bst_i     (bst),
        .ras_ok_i  (ras_ok),
        .dev_i     (dev_st),
        .illegal_o (illegal_c),
        .reason_o  (reason_c)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdm_bank_fsm #(
            .TRCD_C (TRCD_C),
            .TRP_C  (TRP_C),
            .TRAS_C (TRAS_C),
            .BL     (BURST_LEN),
            .CW     (CW)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_i    (cmd),
            .hit_i    ((ba == BAW'(g)) || (cmd == CMD_PREA)),
            .accept_i (!illegal_c),
            .st_o     (bst[g]),
            .ras_ok_o (ras_ok[g])
        );
        assign bank_state_o[3*g +: 3] = bst[g];
    end

    sdm_dev_fsm #(.TRC_C(TRC_C), .TRSC_C(TRSC_C), .CW(CW)) u_dev (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .accept_i (!illegal_c),
        .st_o     (dev_st)
    );

    assign dev_state_o = dev_st;

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_code_o <= CMD_NOP;
            illegal_o  <= 1'b0;
            reason_o   <= RSN_NONE;
        end else begin
            cmd_code_o <= cmd;
            illegal_o  <= illegal_c;
            reason_o   <= reason_c;
        end
    end

    always_comb begin
        all_idle = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bst[b] != BK_IDLE) all_idle = 1'b0;
        end
    end

    // R7
    busy_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_st != DV_READY |-> all_idle);

    // R1
    nop_never_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code_o == CMD_NOP |-> !illegal_o);

    // R2
    flag_has_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> reason_o != RSN_NONE);

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

    localparam int CLK_NS = 10;
    localparam int TRCD   = (20 + CLK_NS - 1) / CLK_NS;
    localparam int TRP    = (20 + CLK_NS - 1) / CLK_NS;
    localparam int TRAS   = (50 + CLK_NS - 1) / CLK_NS;
    localparam int TRC    = (70 + CLK_NS - 1) / CLK_NS;
    localparam int TRSC   = (20 + CLK_NS - 1) / CLK_NS;
    localparam int BL     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        cke = 1'b1, a10 = 1'b0;
    logic [1:0]  ba = 2'd0;
    logic [3:0]  cmd_code_o;
    logic [11:0] bank_state_o;
    logic [1:0]  dev_state_o;
    logic        illegal_o;
    logic [1:0]  reason_o;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_monitor u_sdram_cmd_monitor (
        .clk, .rst_n, .cs_n, .ras_n, .cas_n, .we_n, .cke, .ba, .a10,
        .cmd_code_o, .bank_state_o, .dev_state_o, .illegal_o, .reason_o
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bs(input int b);
        return int'(bank_state_o[3*b +: 3]);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1; a10 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // code: 0 NOP 1 ACT 2 READ 3 READA 4 WRITE 5 WRITEA 6 PRE 7 PREA 8 TBST 9 REF 10 MRS
    task automatic issue(input int code, input int bank);
        cs_n = 1'b0; cke = 1'b1; a10 = 1'b0; ba = 2'(bank);
        case (code)
            1:  {ras_n, cas_n, we_n} = 3'b011;
            2:  {ras_n, cas_n, we_n} = 3'b101;
            3:  begin {ras_n, cas_n, we_n} = 3'b101; a10 = 1'b1; end
            4:  {ras_n, cas_n, we_n} = 3'b100;
            5:  begin {ras_n, cas_n, we_n} = 3'b100; a10 = 1'b1; end
            6:  {ras_n, cas_n, we_n} = 3'b010;
            7:  begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
            8:  {ras_n, cas_n, we_n} = 3'b110;
            9:  {ras_n, cas_n, we_n} = 3'b001;
            10: {ras_n, cas_n, we_n} = 3'b000;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        @(negedge clk);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(0, 0);
    endtask

    function automatic int exp_code(input bit c, input bit r, input bit s, input bit w,
                                    input bit k, input bit a);
        if (!k || c) return 0;
        case ({r, s, w})
            3'b111: return 0;
            3'b011: return 1;
            3'b010: return a ? 7 : 6;
            3'b101: return a ? 3 : 2;
            3'b100: return a ? 5 : 4;
            3'b110: return 8;
            3'b001: return 9;
            default: return 10;
        endcase
    endfunction

    // Distance test: first command, wait, second command at distance d
    task automatic gap_case(input string tag, input int c1, input int c2, input int d, input int exp_rsn);
        do_reset();
        issue(c1, 0);
        nops(d - 1);
        issue(c2, 0);
        chk(tag, int'(illegal_o), (exp_rsn != 0) ? 1 : 0);
        chk(tag, int'(reason_o), exp_rsn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int ec;
        int er;
        do_reset();
        // R2 reset state
        chk("R2 reset code", int'(cmd_code_o), 0);
        chk("R2 reset flag", int'(illegal_o), 0);
        chk("R2 reset banks", int'(bank_state_o), 0);
        chk("R2 reset dev", int'(dev_state_o), 0);

        // R1 R4 R10: exhaustive pin sweep from all-idle
        for (int i = 0; i < 64; i++) begin
            do_reset();
            cs_n = i[0]; ras_n = i[1]; cas_n = i[2]; we_n = i[3]; cke = i[4]; a10 = i[5]; ba = 2'd0;
            @(negedge clk);
            ec = exp_code(i[0], i[1], i[2], i[3], i[4], i[5]);
            er = (ec inside {2, 3, 4, 5, 8}) ? 1 : 0;
            chk("R1 decode", int'(cmd_code_o), ec);
            chk("R4 idle bank rule", int'(reason_o), er);
            chk("R10 bank0 after sweep cmd", bs(0), (ec == 1) ? ((TRCD > 1) ? 1 : 2) : 0);
            chk("R7 dev after sweep cmd", int'(dev_state_o),
                (ec == 9 && TRC > 1) ? 1 : ((ec == 10 && TRSC > 1) ? 2 : 0));
        end

        // R3 R12: ACT to READ distance
        for (int d = 1; d <= TRCD + 2; d++) gap_case("R3 tRCD", 1, 2, d, (d < TRCD) ? 3 : 0);
        // R5: ACT to PRE distance (tRAS)
        for (int d = 1; d <= TRAS + 2; d++) gap_case("R5 tRAS", 1, 6, d, (d < TRAS) ? 3 : 0);
        // R7: REF to ACT, MRS to ACT
        for (int d = 1; d <= TRC + 2; d++) gap_case("R7 tRC", 9, 1, d, (d < TRC) ? 3 : 0);
        for (int d = 1; d <= TRSC + 2; d++) gap_case("R7 tRSC", 10, 1, d, (d < TRSC) ? 3 : 0);

        // R5: PRE to ACT distance (tRP)
        for (int d = 1; d <= TRP + 2; d++) begin
            do_reset();
            issue(1, 0);
            nops(TRAS - 1);
            issue(6, 0);
            chk("R5 PRE legal", int'(illegal_o), 0);
            nops(d - 1);
            issue(1, 0);
            chk("R5 tRP", int'(reason_o), (d < TRP) ? 3 : 0);
        end

        // R4: ACT to an open bank
        do_reset();
        issue(1, 1);
        nops(TRCD);
        issue(1, 1);
        chk("R4 ACT open bank", int'(reason_o), 1);
        chk("R10 open bank kept", bs(1), 2);

        // R6: REF/MRS with a bank not idle
        do_reset();
        issue(1, 1);
        issue(9, 0);
        chk("R6 REF not idle", int'(reason_o), 2);
        chk("R10 dev unchanged", int'(dev_state_o), 0);
        issue(10, 0);
        chk("R6 MRS not idle", int'(reason_o), 2);

        // R8: plain burst length and return to OPEN
        do_reset();
        issue(1, 0);
        nops(TRCD - 1);
        issue(2, 0);
        chk("R8 burst state", bs(0), (BL > 1) ? 3 : 2);
        for (int j = 1; j <= BL; j++) begin
            issue(0, 0);
            chk("R8 burst progress", bs(0), (j < BL - 1) ? 3 : 2);
        end
        // R8: restart by WRITE during READ burst
        issue(2, 0);
        issue(0, 0);
        issue(4, 0);
        chk("R8 restart legal", int'(illegal_o), 0);
        chk("R8 restart state", bs(0), 4);
        nops(BL - 2);
        chk("R8 restarted burst holds", bs(0), 4);
        issue(0, 0);
        chk("R8 restarted burst ends", bs(0), 2);
        // R8: TBST ends a burst
        issue(2, 0);
        issue(8, 0);
        chk("R8 TBST legal", int'(illegal_o), 0);
        chk("R8 TBST state", bs(0), 2);
        // R8: PRE during burst (tRAS long past)
        issue(2, 0);
        issue(6, 0);
        chk("R8 PRE in burst", int'(illegal_o), 0);
        chk("R8 PRE in burst state", bs(0), 7);

        // R9: auto-precharge burst, ACT distance
        for (int d = 1; d <= BL + TRP + 1; d++) begin
            do_reset();
            issue(1, 0);
            nops(TRCD - 1);
            issue(3, 0);
            nops(d - 1);
            issue(1, 0);
            chk("R9 ACT after READA", int'(reason_o), (d < BL) ? 1 : ((d < BL + TRP) ? 3 : 0));
        end
        do_reset();
        issue(1, 0);
        nops(TRCD - 1);
        issue(5, 0);
        issue(6, 0);
        chk("R9 PRE during WRITEA", int'(reason_o), 1);
        issue(2, 0);
        chk("R9 READ during WRITEA", int'(reason_o), 1);
        chk("R10 WRITEA kept", bs(0), 6);

        // R13: independent banks
        do_reset();
        issue(1, 0);
        issue(1, 2);
        chk("R13 bank0 opened", bs(0), 2);
        chk("R13 bank1 untouched", bs(1), 0);
        chk("R13 bank2 opening", bs(2), 1);
        chk("R13 bank3 untouched", bs(3), 0);
        issue(2, 2);
        chk("R13 early READ bank2", int'(reason_o), 3);
        issue(2, 0);
        chk("R13 READ bank0", int'(illegal_o), 0);

        // R11: PREA timing reason, then legal PREA
        do_reset();
        issue(1, 0);
        nops(TRAS - 1);
        issue(1, 1);
        issue(7, 0);
        chk("R11 PREA timing", int'(reason_o), 3);
        nops(TRAS - 2);
        issue(7, 0);
        chk("R11 PREA legal", int'(illegal_o), 0);
        chk("R11 bank0 closing", bs(0), (TRP > 1) ? 7 : 0);
        chk("R11 bank1 closing", bs(1), (TRP > 1) ? 7 : 0);
        chk("R11 bank2 idle", bs(2), 0);
        // R11: PREA bank-state reason
        do_reset();
        issue(1, 0);
        issue(1, 1);
        nops(TRAS - 1);
        issue(3, 0);
        issue(7, 0);
        chk("R11 PREA bank reason", int'(reason_o), 1);
        chk("R10 bank1 kept open", bs(1), 2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule